// File: doc/BRIEF.md
# PHY Strap Configuration Register Controller

This block keeps one 32-bit configuration word for an Ethernet MAC and PHY pair. Software reaches it through a plain synchronous write strobe with a 32-bit data bus and a read bus that always shows the current word. Bit 31 selects an internal or external PHY, and bits 30:28 select the MAC interface. Both are driven straight out to the MAC. The lower 25 bits are PHY straps. They do not act on the PHY directly. A shadow copy takes them in at the clock edge where the PHY reset is released, and the PHY reads its defaults from that copy.

The block sequences two resets. The PHY reset is held during chip reset. It is also held while software keeps the soft-restart bit at 1, and it is released a fixed number of cycles after that bit is written back to 0. The MAC reset is a pulse of fixed length, fired whenever a write changes the interface-select field. A small decoder turns the latched auto-negotiation enable and mode bits into a four-bit speed and duplex ability vector, plus an auto-negotiation flag.

Top module: `strap_cfg_ctrl`

## Requirements
- R1: `ext_phy_sel` always equals register bit 31 (0 internal, 1 external). `mac_if_sel` always equals bits 30:28 (0 is MII, 4 is RMII, other codes reserved but stored as written). Both follow a write from the edge that performs it.
- R2: Bits 27, 26, 24 and 11 always read 0, and writes to them are ignored.
- R3: After chip reset the word reads 0x0080040E: bit 23 = 1, bit 10 = 1, bit 3 = 1, bits 2:1 = 3, every other bit 0.
- R4: A write whose bits 30:28 differ from the stored field makes `mac_rst` high for exactly MAC_RST_CYCLES cycles, starting at the write edge. A write that leaves the field unchanged produces no pulse.
- R5: `phy_rst` is high during chip reset. After chip reset is released it stays high for PHY_HOLD_CYCLES-1 cycles. It is high in every cycle where bit 25 reads 1. After the edge that writes bit 25 back to 0 it stays high for exactly PHY_HOLD_CYCLES cycles. A soft restart leaves the register contents unchanged.
- R6: `strap_dflt` takes register bits 24:0 at the edge where `phy_rst` falls, and holds its value at every other time. Writes made while the PHY is out of reset do not reach it.
- R7: `ability` is ordered {100 full, 100 half, 10 full, 10 half} and is computed from shadow bit 3 (enable) and shadow bits 2:1 (mode). With bit 3 = 0, modes 0/1/2/3 give 0001/0010/0100/1000. With bit 3 = 1, they give 0011/1100/0101/1111.
- R8: `tx_hold` equals shadow bit 0. A 1 keeps the PHY from driving energy onto the line.
- R9: `aneg_active` equals shadow bit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low chip reset |
| wr_en | input | 1 | Write strobe for one cycle |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Current register word |
| ext_phy_sel | output | 1 | PHY source select (bit 31) |
| mac_if_sel | output | 3 | MAC interface select (bits 30:28) |
| mac_rst | output | 1 | MAC reset pulse |
| phy_rst | output | 1 | PHY reset, active high |
| strap_dflt | output | 25 | Latched strap defaults for the PHY |
| ability | output | 4 | Decoded speed/duplex ability |
| aneg_active | output | 1 | Latched auto-negotiation enable |
| tx_hold | output | 1 | Latched transmit hold-off |

## Verification
The properties assume three things about the bus. `wr_en` lasts one cycle per access. `wr_data` is sampled only while `wr_en` is high. No write coincides with the edge where the PHY reset is released, because a write on that edge would race the shadow capture. The stimulus respects this. Every soft restart ends with a single write of 0 to bit 25, followed by idle cycles until `phy_rst` is seen low. Random writes keep bit 25 clear and are spaced so that each MAC reset pulse has finished before the next access.

// File: rtl/strap_cfg_pkg.sv
// Package: shared constants for the strap configuration register.
// Assumes a 32-bit word. Bit positions below are the ones the PHY and MAC
// decode; fixed-zero bits are listed in the write mask.
package strap_cfg_pkg;
    localparam int CFG_W      = 32;
    localparam int STRAP_W    = 25;
    localparam int IF_W       = 3;
    localparam int MODE_W     = 2;
    localparam int ABIL_W     = 4;

    localparam int BIT_EXT    = 31;
    localparam int IF_HI      = 30;
    localparam int IF_LO      = 28;
    localparam int BIT_RSTRT  = 25;
    localparam int BIT_ANEG   = 3;
    localparam int MODE_HI    = 2;
    localparam int MODE_LO    = 1;
    localparam int BIT_HOLD   = 0;

    // Reset word: bits 23, 10, 3 set and mode field = 3.
    localparam logic [CFG_W-1:0] CFG_RST_VAL = 32'h0080_040E;
    // Bits software may change; 27, 26, 24 and 11 are fixed at zero.
    localparam logic [CFG_W-1:0] CFG_WR_MASK = 32'hF2FF_F7FF;

    typedef logic [IF_W-1:0]   if_sel_t;
    typedef logic [STRAP_W-1:0] strap_t;
endpackage

// File: rtl/strap_regfile.sv
// strap_regfile: stores the configuration word.
// Only bits in CFG_WR_MASK are writable; every other bit keeps its reset
// value (zero), so reserved and read-only bits never change.
// Assumes wr_en is a single-cycle strobe in the clk domain.
module strap_regfile
    import strap_cfg_pkg::*;
#(
    parameter logic [CFG_W-1:0] RST_VAL = CFG_RST_VAL,
    parameter logic [CFG_W-1:0] WR_MASK = CFG_WR_MASK
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wr_data,
    output logic [CFG_W-1:0] cfg_q
);
    localparam logic [CFG_W-1:0] HOLD_MASK = ~WR_MASK;

    logic [CFG_W-1:0] cfg_r;

    // Purpose: load reset word, or merge writable bits of a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_r <= RST_VAL;
        end else if (wr_en) begin
            cfg_r <= (wr_data & WR_MASK) | (cfg_r & HOLD_MASK);
        end
    end

    // Purpose: present the word with non-writable bits forced to zero.
    always_comb begin
        cfg_q = cfg_r & WR_MASK;
    end
endmodule

// File: rtl/mac_rst_gen.sv
// mac_rst_gen: fires a MAC reset pulse of PULSE_CYCLES cycles when a write
// changes the interface-select field. A change written during a pulse
// restarts the full length. Assumes PULSE_CYCLES >= 1.
module mac_rst_gen
    import strap_cfg_pkg::*;
#(
    parameter int PULSE_CYCLES = 4
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    wr_en,
    input  if_sel_t if_new,
    input  if_sel_t if_cur,
    output logic    mac_rst
);
    localparam int CNT_W = $clog2(PULSE_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(PULSE_CYCLES);

    logic [CNT_W-1:0] cnt_r;
    logic             change;

    // Purpose: detect a write that alters the stored interface code.
    always_comb begin
        change = wr_en && (if_new != if_cur);
    end

    // Purpose: load the pulse length on a change, then count down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_r <= '0;
        end else if (change) begin
            cnt_r <= CNT_LOAD;
        end else if (cnt_r != '0) begin
            cnt_r <= cnt_r - 1'b1;
        end
    end

    // Purpose: pulse is active while the counter is non-zero.
    always_comb begin
        mac_rst = (cnt_r != '0);
    end
endmodule

// File: rtl/phy_restart_seq.sv
// phy_restart_seq: drives the PHY reset and the strap shadow.
// The reset is high in chip reset and while the restart bit is 1. After the
// restart bit clears, it holds for HOLD_CYCLES more cycles. The strap
// shadow is loaded on the edge where the reset falls.
// Assumes HOLD_CYCLES >= 1 and no write on the release edge.
module phy_restart_seq
    import strap_cfg_pkg::*;
#(
    parameter int HOLD_CYCLES = 8,
    parameter logic [STRAP_W-1:0] SHADOW_RST = CFG_RST_VAL[STRAP_W-1:0]
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   restart_req,
    input  strap_t strap_live,
    output logic   phy_rst,
    output strap_t strap_dflt
);
    localparam int CNT_W = $clog2(HOLD_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(HOLD_CYCLES);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(1);

    logic [CNT_W-1:0] hold_r;
    strap_t           shadow_r;
    logic             release_now;

    // Purpose: reload the hold counter on reset or restart, else count down.
    always_ff @(posedge clk) begin
        if (!rst_n || restart_req) begin
            hold_r <= CNT_LOAD;
        end else if (hold_r != '0) begin
            hold_r <= hold_r - 1'b1;
        end
    end

    // Purpose: flag the edge on which the PHY reset is released.
    always_comb begin
        release_now = rst_n && !restart_req && (hold_r == CNT_LAST);
    end

    // Purpose: latch the straps into the shadow at reset release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_r <= SHADOW_RST;
        end else if (release_now) begin
            shadow_r <= strap_live;
        end
    end

    // Purpose: PHY reset output and shadow view.
    always_comb begin
        phy_rst    = (hold_r != '0) || restart_req;
        strap_dflt = shadow_r;
    end
endmodule

// File: rtl/ability_decode.sv
// ability_decode: maps the auto-negotiation enable and mode bits to an
// ability vector {100FD, 100HD, 10FD, 10HD}. With negotiation off, the mode
// forces one ability; with it on, the mode selects an advertised set.
// Purely combinational.
module ability_decode
    import strap_cfg_pkg::*;
(
    input  logic              aneg_en,
    input  logic [MODE_W-1:0] mode,
    output logic [ABIL_W-1:0] ability
);
    localparam logic [ABIL_W-1:0] ONE_HOT_BASE = ABIL_W'(1);

    // Purpose: pick the forced single ability or the advertised set.
    always_comb begin
        if (!aneg_en) begin
            ability = ONE_HOT_BASE << mode;
        end else begin
            unique case (mode)
                2'd0:    ability = 4'b0011;
                2'd1:    ability = 4'b1100;
                2'd2:    ability = 4'b0101;
                default: ability = 4'b1111;
            endcase
        end
    end
endmodule

// File: rtl/strap_cfg_ctrl.sv
// strap_cfg_ctrl: top of the PHY strap configuration controller.
// Ties together the register, the MAC reset pulse, the PHY restart and
// shadow latch, and the ability decode. The ability outputs come from the
// shadow, not the live word. Assumes a synchronous active-low chip reset.
module strap_cfg_ctrl
    import strap_cfg_pkg::*;
#(
    parameter int PHY_HOLD_CYCLES = 8,
    parameter int MAC_RST_CYCLES  = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [CFG_W-1:0]    wr_data,
    output logic [CFG_W-1:0]    rd_data,
    output logic                ext_phy_sel,
    output logic [IF_W-1:0]     mac_if_sel,
    output logic                mac_rst,
    output logic                phy_rst,
    output logic [STRAP_W-1:0]  strap_dflt,
    output logic [ABIL_W-1:0]   ability,
    output logic                aneg_active,
    output logic                tx_hold
);
    logic [CFG_W-1:0] cfg_q;
    strap_t           shadow;

    strap_regfile #(
        .RST_VAL (CFG_RST_VAL),
        .WR_MASK (CFG_WR_MASK)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .cfg_q   (cfg_q)
    );

    mac_rst_gen #(
        .PULSE_CYCLES (MAC_RST_CYCLES)
    ) u_mac_rst (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .if_new  (wr_data[IF_HI:IF_LO]),
        .if_cur  (cfg_q[IF_HI:IF_LO]),
        .mac_rst (mac_rst)
    );

    phy_restart_seq #(
        .HOLD_CYCLES (PHY_HOLD_CYCLES),
        .SHADOW_RST  (CFG_RST_VAL[STRAP_W-1:0])
    ) u_phy_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .restart_req (cfg_q[BIT_RSTRT]),
        .strap_live  (cfg_q[STRAP_W-1:0]),
        .phy_rst     (phy_rst),
        .strap_dflt  (shadow)
    );

    ability_decode u_abil (
        .aneg_en (shadow[BIT_ANEG]),
        .mode    (shadow[MODE_HI:MODE_LO]),
        .ability (ability)
    );

    // Purpose: drive the live-register and shadow-derived outputs.
    always_comb begin
        rd_data     = cfg_q;
        ext_phy_sel = cfg_q[BIT_EXT];
        mac_if_sel  = cfg_q[IF_HI:IF_LO];
        strap_dflt  = shadow;
        aneg_active = shadow[BIT_ANEG];
        tx_hold     = shadow[BIT_HOLD];
    end
endmodule

// File: rtl/strap_cfg_ctrl_chk.sv
// strap_cfg_ctrl_chk: property checker bound to strap_cfg_ctrl.
// Assumes single-cycle write strobes and no write on the PHY release edge.
module strap_cfg_ctrl_chk #(
    parameter int PHY_HOLD_CYCLES = 8
) (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic [31:0] wr_data,
    input logic [31:0] rd_data,
    input logic        mac_rst,
    input logic        phy_rst,
    input logic [24:0] strap_dflt,
    input logic [3:0]  ability,
    input logic        aneg_active
);
    logic [15:0] run_r;

    // Purpose: count consecutive sampled cycles with the PHY reset high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_r <= '0;
        end else if (phy_rst) begin
            run_r <= (run_r == 16'hFFFF) ? run_r : run_r + 1'b1;
        end else begin
            run_r <= '0;
        end
    end

    AST_FIXED_ZERO_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[27:26] == 2'b00) && !rd_data[24] && !rd_data[11]); // R2

    AST_MAC_RST_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_data[30:28] != rd_data[30:28])) |=> mac_rst); // R4

    AST_MAC_RST_ONLY_AFTER_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mac_rst) |-> $past(wr_en && (wr_data[30:28] != rd_data[30:28]))); // R4

    AST_PHY_RST_WHILE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[25] |-> phy_rst); // R5

    AST_PHY_RST_MIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!phy_rst && $past(phy_rst)) |-> (run_r >= 16'(PHY_HOLD_CYCLES))); // R5

    AST_SHADOW_ONLY_ON_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(phy_rst) |-> $stable(strap_dflt)); // R6

    AST_FORCED_SINGLE_ABILITY: assert property (@(posedge clk) disable iff (!rst_n)
        !aneg_active |-> ($countones(ability) == 1)); // R7

    AST_ANEG_SET_ABILITY: assert property (@(posedge clk) disable iff (!rst_n)
        aneg_active |-> ($countones(ability) >= 2)); // R7
endmodule

bind strap_cfg_ctrl strap_cfg_ctrl_chk #(
    .PHY_HOLD_CYCLES (PHY_HOLD_CYCLES)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_data     (wr_data),
    .rd_data     (rd_data),
    .mac_rst     (mac_rst),
    .phy_rst     (phy_rst),
    .strap_dflt  (strap_dflt),
    .ability     (ability),
    .aneg_active (aneg_active)
);

// File: tb/strap_cfg_ctrl_tb.sv
module strap_cfg_ctrl_tb;
    localparam int HOLD = 8;
    localparam int MLEN = 4;
    localparam logic [31:0] MASK = 32'hF2FF_F7FF;
    localparam logic [31:0] RSTV = 32'h0080_040E;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        ext_phy_sel;
    logic [2:0]  mac_if_sel;
    logic        mac_rst;
    logic        phy_rst;
    logic [24:0] strap_dflt;
    logic [3:0]  ability;
    logic        aneg_active;
    logic        tx_hold;

    int tests = 0;
    int fails = 0;
    logic [31:0] exp_reg;
    logic [24:0] exp_shadow;

    always #2.5 clk = ~clk;

    strap_cfg_ctrl #(.PHY_HOLD_CYCLES(HOLD), .MAC_RST_CYCLES(MLEN)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .ext_phy_sel(ext_phy_sel), .mac_if_sel(mac_if_sel),
        .mac_rst(mac_rst), .phy_rst(phy_rst), .strap_dflt(strap_dflt),
        .ability(ability), .aneg_active(aneg_active), .tx_hold(tx_hold)
    );

    function automatic logic [3:0] exp_ab(input logic an, input logic [1:0] m);
        if (!an) return 4'b0001 << m;
        case (m)
            2'd0: return 4'b0011;
            2'd1: return 4'b1100;
            2'd2: return 4'b0101;
            default: return 4'b1111;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Counts negedges with mac_rst high over a window after a write.
    task automatic count_mac(output int n);
        n = 0;
        for (int k = 0; k < MLEN + 3; k++) begin
            if (mac_rst) n++;
            @(negedge clk);
        end
    endtask

    task automatic count_phy(output int n);
        n = 0;
        while (phy_rst && n < 200) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic check_shadow_outs(input string tag);
        check({tag, " R6 shadow"}, 32'(strap_dflt), 32'(exp_shadow));
        check("R7 ability", 32'(ability), 32'(exp_ab(exp_shadow[3], exp_shadow[2:1])));
        check("R8 tx_hold", 32'(tx_hold), 32'(exp_shadow[0]));
        check("R9 aneg_active", 32'(aneg_active), 32'(exp_shadow[3]));
    endtask

    initial begin
        #(200000 * 5);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int n;
        logic [31:0] d;
        logic chg;
        void'($urandom(32'd4242));

        // Reset state
        repeat (3) @(negedge clk);
        check("R3 reset word", rd_data, RSTV);
        check("R5 phy_rst in chip reset", 32'(phy_rst), 32'd1);
        check("R4 no mac_rst in reset", 32'(mac_rst), 32'd0);
        check("R1 ext_phy reset", 32'(ext_phy_sel), 32'd0);
        check("R1 if_sel reset", 32'(mac_if_sel), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        count_phy(n);
        check("R5 hold after chip reset", 32'(n), 32'(HOLD - 1));
        exp_reg = RSTV;
        exp_shadow = RSTV[24:0];
        check_shadow_outs("post-reset");

        // R2: fixed-zero bits ignore writes
        wr(32'h0D00_0800);
        check("R2 fixed bits", rd_data, 32'h0);
        exp_reg = 32'h0;
        count_mac(n);
        check("R4 no pulse same if", 32'(n), 32'd0);

        // R4 directed: reserved code stored and pulses
        wr(32'h5000_0000);
        check("R1 reserved code kept", 32'(mac_if_sel), 32'd5);
        count_mac(n);
        check("R4 pulse length", 32'(n), 32'(MLEN));
        exp_reg = 32'h5000_0000;
        wr(32'h4000_0000);
        check("R1 RMII code", 32'(mac_if_sel), 32'd4);
        count_mac(n);
        check("R4 pulse on change", 32'(n), 32'(MLEN));
        exp_reg = 32'h4000_0000;

        // Random writes, bit 25 clear
        for (int i = 0; i < 40; i++) begin
            d = $urandom;
            d[25] = 1'b0;
            if (i % 4 == 0) d[30:28] = exp_reg[30:28];
            chg = (d[30:28] != exp_reg[30:28]);
            wr(d);
            exp_reg = d & MASK;
            check("R2 rd_data", rd_data, exp_reg);
            check("R1 ext_phy", 32'(ext_phy_sel), 32'(exp_reg[31]));
            check("R1 if_sel", 32'(mac_if_sel), 32'(exp_reg[30:28]));
            check("R5 no restart phy_rst", 32'(phy_rst), 32'd0);
            count_mac(n);
            check("R4 random pulse", 32'(n), chg ? 32'(MLEN) : 32'd0);
            check("R6 write not in shadow", 32'(strap_dflt), 32'(exp_shadow));
        end

        // Soft restart across all enable/mode combinations
        for (int i = 0; i < 8; i++) begin
            d = $urandom;
            d[25] = 1'b0;
            d[3] = i[2];
            d[2:1] = i[1:0];
            d[0] = i[0];
            wr(d | 32'h0200_0000);
            check("R5 phy_rst on bit25", 32'(phy_rst), 32'd1);
            repeat (HOLD + 5) @(negedge clk);
            check("R5 still held while bit25", 32'(phy_rst), 32'd1);
            check("R6 shadow held in restart", 32'(strap_dflt), 32'(exp_shadow));
            wr(d);
            exp_reg = d & MASK;
            count_phy(n);
            check("R5 hold after clear", 32'(n), 32'(HOLD));
            exp_shadow = exp_reg[24:0];
            check_shadow_outs("restart");
            check("R5 register kept", rd_data, exp_reg);
            repeat (MLEN + 2) @(negedge clk);
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule